// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command side of a two-bank synchronous DRAM from reset until the memory is ready for normal traffic. From the first clock after reset it presents a no-operation command with clock-enable high and the data mask high, so the data pins stay high-impedance. It then waits out a long power-up pause and closes both banks with a precharge-all command. Next it loads the mode register and issues a burst of auto-refresh commands. A parameter selects which of these two steps comes first.

Every gap between two commands is a minimum time given in nanoseconds. At elaboration the block turns each gap into a cycle count at the configured clock period, rounding up, and drives no-operation for the whole of each wait. When the last gap has run out the block raises `init_done` and releases the data mask. `init_done` then stays high until the next reset. A controller placed after this block takes over the command bus at that point.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high, and in the cycle it is released, the outputs show a no-operation command (CS# 0, RAS# 1, CAS# 1, WE# 1), CKE 1, DQM 1, `init_done` 0, and address and bank 0.
- R2: The first command other than no-operation appears exactly ceil(PAUSE_NS/TCK_NS) cycles after reset is released. Before it the bus shows no-operation only, with DQM high.
- R3: The first command is a precharge-all: CS# 0, RAS# 0, CAS# 1, WE# 0, address bit AP_BIT 1, all other address bits 0, bank 0.
- R4: The mode register load is encoded CS# 0, RAS# 0, CAS# 0, WE# 0, with the address equal to MODE_WORD and bank 0. It is issued exactly once.
- R5: Exactly N_REFRESH auto-refresh commands are issued (CS# 0, RAS# 0, CAS# 0, WE# 1), each with address and bank 0.
- R6: With REFRESH_FIRST = 0 the mode register load follows the precharge and the refresh burst follows it. With REFRESH_FIRST = 1 the refresh burst follows the precharge and the mode load comes last.
- R7: The gap to the next command is ceil(TRP_NS/TCK_NS) cycles after the precharge, ceil(TRC_NS/TCK_NS) after each refresh and ceil(TRSC_NS/TCK_NS) after the mode load. No-operation fills every gap, and a gap of one cycle means the commands are back-to-back.
- R8: `init_done` rises in the cycle where the gap after the last command ends, that is the last command's cycle plus its gap. It stays high until reset, and DQM is low exactly while `init_done` is high. No command other than no-operation follows.
- R9: A reset asserted at any point, including in the middle of the sequence, restarts the whole sequence from the power-up pause.
- R10: CKE is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its period is TCK_NS |
| rst | input | 1 | Synchronous active-high reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable, always high |
| sd_dqm | output | 1 | Data mask, high until init_done |
| sd_addr | output | ADDR_W | Address lines; auto-precharge bit or mode word |
| sd_ba | output | BANK_W | Bank select, always 0 during init |
| init_done | output | 1 | Sequence finished; sticky until reset |

## Verification
The bench builds two copies of the block. The first runs at a 10 ns clock period with a 400 ns pause and the mode load first. Its mode-load gap rounds to one cycle, so the back-to-back path is exercised. The second runs at 5 ns with a 300 ns pause and the refresh burst first, so every gap is several cycles long and the other ordering is covered. The short pauses keep each full sequence, and the resets in mid-sequence, to a few hundred cycles, while the rounding is still checked against the cycle counts required at both periods.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_MRS = 2'd2,
    CMD_REF = 2'd3
  } init_cmd_t;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_MRS,
    ST_REF,
    ST_WAIT,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int tck_ns);
    int c;
    c = (ns + tck_ns - 1) / tck_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic cmd_pins_t encode_cmd(input init_cmd_t c);
    cmd_pins_t p;
    case (c)
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CNT_W'(RST_VAL);
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign busy   = (cnt != '0);
  assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int N_REFRESH     = 8,
  parameter bit REFRESH_FIRST = 1'b0,
  parameter int CNT_W         = 16,
  parameter int RP_CYC        = 2,
  parameter int RC_CYC        = 5,
  parameter int RSC_CYC       = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             timer_expire,
  output init_cmd_t        cmd,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             done
);

  localparam int REF_W = $clog2(N_REFRESH + 1);

  seq_state_t       state, pend, follow;
  logic [REF_W-1:0] ref_cnt;
  logic             last_ref;
  logic             is_cmd;
  logic [CNT_W-1:0] gap_cyc;

  assign last_ref = (ref_cnt == REF_W'(N_REFRESH - 1));

  always_comb begin
    cmd     = CMD_NOP;
    follow  = ST_DONE;
    gap_cyc = CNT_W'(1);
    is_cmd  = 1'b0;
    case (state)
      ST_PRE: begin
        cmd     = CMD_PRE;
        is_cmd  = 1'b1;
        gap_cyc = CNT_W'(RP_CYC);
        follow  = REFRESH_FIRST ? ST_REF : ST_MRS;
      end
      ST_MRS: begin
        cmd     = CMD_MRS;
        is_cmd  = 1'b1;
        gap_cyc = CNT_W'(RSC_CYC);
        follow  = REFRESH_FIRST ? ST_DONE : ST_REF;
      end
      ST_REF: begin
        cmd     = CMD_REF;
        is_cmd  = 1'b1;
        gap_cyc = CNT_W'(RC_CYC);
        if (!last_ref)          follow = ST_REF;
        else if (REFRESH_FIRST) follow = ST_MRS;
        else                    follow = ST_DONE;
      end
      default: ;
    endcase
  end

  // A gap of one cycle needs no wait state; longer gaps park in ST_WAIT.
  assign timer_load = is_cmd && (gap_cyc > CNT_W'(1));
  assign timer_val  = gap_cyc - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PAUSE;
      pend    <= ST_DONE;
      ref_cnt <= '0;
    end else begin
      case (state)
        ST_PAUSE: if (timer_expire) state <= ST_PRE;
        ST_WAIT:  if (timer_expire) state <= pend;
        ST_PRE, ST_MRS, ST_REF: begin
          if (timer_load) begin
            state <= ST_WAIT;
            pend  <= follow;
          end else begin
            state <= follow;
          end
          if (state == ST_REF) ref_cnt <= ref_cnt + REF_W'(1);
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/sdram_init_cmd_drv.sv
module sdram_init_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W    = 11,
  parameter int                BANK_W    = 1,
  parameter int                AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  init_cmd_t         cmd,
  output cmd_pins_t         pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              fire
);

  assign pins = encode_cmd(cmd);
  assign fire = (cmd != CMD_NOP);
  assign ba   = '0;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_addr
    if (b == AP_BIT) begin : g_ap
      assign addr[b] = (cmd == CMD_MRS) ? MODE_WORD[b] : (cmd == CMD_PRE);
    end else begin : g_plain
      assign addr[b] = (cmd == CMD_MRS) & MODE_WORD[b];
    end
  end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int                TCK_NS        = 10,
  parameter int                PAUSE_NS      = 200000,
  parameter int                TRP_NS        = 15,
  parameter int                TRC_NS        = 45,
  parameter int                TRSC_NS       = 10,
  parameter int                N_REFRESH     = 8,
  parameter bit                REFRESH_FIRST = 1'b0,
  parameter int                ADDR_W        = 11,
  parameter int                BANK_W        = 1,
  parameter int                AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD    = 11'h020
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_done
);

  localparam int PAUSE_CYC = ns_to_cycles(PAUSE_NS, TCK_NS);
  localparam int RP_CYC    = ns_to_cycles(TRP_NS, TCK_NS);
  localparam int RC_CYC    = ns_to_cycles(TRC_NS, TCK_NS);
  localparam int RSC_CYC   = ns_to_cycles(TRSC_NS, TCK_NS);
  localparam int MAX_CYC   = max_of(max_of(PAUSE_CYC, RP_CYC), max_of(RC_CYC, RSC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  // Named internal events, visible to the bound checker.
  logic             timer_busy;
  logic             timer_expire;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             cmd_fire;
  init_cmd_t        cur_cmd;
  cmd_pins_t        pins;
  logic             seq_done;

  sdram_init_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PAUSE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .busy     (timer_busy),
    .expire   (timer_expire)
  );

  sdram_init_fsm #(
    .N_REFRESH     (N_REFRESH),
    .REFRESH_FIRST (REFRESH_FIRST),
    .CNT_W         (CNT_W),
    .RP_CYC        (RP_CYC),
    .RC_CYC        (RC_CYC),
    .RSC_CYC       (RSC_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .timer_expire (timer_expire),
    .cmd          (cur_cmd),
    .timer_load   (timer_load),
    .timer_val    (timer_val),
    .done         (seq_done)
  );

  sdram_init_cmd_drv #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .AP_BIT    (AP_BIT),
    .MODE_WORD (MODE_WORD)
  ) u_drv (
    .cmd  (cur_cmd),
    .pins (pins),
    .addr (sd_addr),
    .ba   (sd_ba),
    .fire (cmd_fire)
  );

  assign sd_cs_n   = pins.cs_n;
  assign sd_ras_n  = pins.ras_n;
  assign sd_cas_n  = pins.cas_n;
  assign sd_we_n   = pins.we_n;
  assign sd_cke    = 1'b1;
  assign sd_dqm    = ~seq_done;
  assign init_done = seq_done;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int ADDR_W    = 11,
  parameter int BANK_W    = 1,
  parameter int AP_BIT    = 10,
  parameter int N_REFRESH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_cke,
  input logic              sd_dqm,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BANK_W-1:0] sd_ba,
  input logic              init_done,
  input logic              timer_busy,
  input logic              cmd_fire
);

  logic [3:0]  bus;
  logic [15:0] ref_seen;

  assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst)
      ref_seen <= '0;
    else if (bus == 4'b0001)
      ref_seen <= ref_seen + 16'd1;
  end

  p_cke_high_r10: assert property (@(posedge clk) disable iff (rst) sd_cke);

  p_quiet_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
    timer_busy |-> (bus == 4'b0111));

  p_fire_outside_wait_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |-> !timer_busy);

  p_precharge_all_r3: assert property (@(posedge clk) disable iff (rst)
    (bus == 4'b0010) |-> (sd_addr == (ADDR_W'(1) << AP_BIT)) && (sd_ba == '0));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done && !sd_dqm);

  p_silent_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> !cmd_fire && (bus == 4'b0111));

  p_ref_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (bus == 4'b0001) |-> (ref_seen < 16'(N_REFRESH)));

  p_ref_total_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (ref_seen == 16'(N_REFRESH)));

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W    (ADDR_W),
  .BANK_W    (BANK_W),
  .AP_BIT    (AP_BIT),
  .N_REFRESH (N_REFRESH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sd_cs_n    (sd_cs_n),
  .sd_ras_n   (sd_ras_n),
  .sd_cas_n   (sd_cas_n),
  .sd_we_n    (sd_we_n),
  .sd_cke     (sd_cke),
  .sd_dqm     (sd_dqm),
  .sd_addr    (sd_addr),
  .sd_ba      (sd_ba),
  .init_done  (init_done),
  .timer_busy (timer_busy),
  .cmd_fire   (cmd_fire)
);

// File: tb/sdram_pwrup_seq_bench.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_bench;

  localparam int NREF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // Instance A: 10 ns period, 400 ns pause, mode load first.
  logic        a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done;
  logic [10:0] a_addr;
  logic [0:0]  a_ba;
  // Instance B: 5 ns period, 300 ns pause, refresh burst first.
  logic        b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done;
  logic [10:0] b_addr;
  logic [0:0]  b_ba;

  sdram_pwrup_seq #(
    .TCK_NS (10), .PAUSE_NS (400), .N_REFRESH (NREF),
    .REFRESH_FIRST (1'b0), .MODE_WORD (11'h232)
  ) u_sdram_pwrup_seq (
    .clk (clk), .rst (rst), .sd_cs_n (a_cs), .sd_ras_n (a_ras),
    .sd_cas_n (a_cas), .sd_we_n (a_we), .sd_cke (a_cke), .sd_dqm (a_dqm),
    .sd_addr (a_addr), .sd_ba (a_ba), .init_done (a_done)
  );

  sdram_pwrup_seq #(
    .TCK_NS (5), .PAUSE_NS (300), .N_REFRESH (NREF),
    .REFRESH_FIRST (1'b1), .MODE_WORD (11'h0A5)
  ) u_sdram_pwrup_seq_rf (
    .clk (clk), .rst (rst), .sd_cs_n (b_cs), .sd_ras_n (b_ras),
    .sd_cas_n (b_cas), .sd_we_n (b_we), .sd_cke (b_cke), .sd_dqm (b_dqm),
    .sd_addr (b_addr), .sd_ba (b_ba), .init_done (b_done)
  );

  // Reference model: schedule of expected commands, keyed by inst*100000+cycle.
  // Codes: 0 no-op, 1 precharge-all, 2 mode load, 3 auto-refresh.
  int plan [int];
  int done_at [2];
  int pause_at [2];
  int mode_w [2];
  int k = 0;
  int checks = 0;
  int fails = 0;
  bit restarted = 1'b0;
  bit finished = 1'b0;

  function automatic int cycles_for(input int ns, input int tck);
    int c = 0;
    while (c * tck < ns) c++;
    if (c == 0) c = 1;
    return c;
  endfunction

  task automatic build(input int i, input int tck, input int pause_ns, input bit rfirst, input int mw);
    int t;
    t = cycles_for(pause_ns, tck);
    pause_at[i] = t;
    mode_w[i] = mw;
    plan[i*100000 + t] = 1;           t += cycles_for(15, tck);
    if (!rfirst) begin plan[i*100000 + t] = 2; t += cycles_for(10, tck); end
    for (int r = 0; r < NREF; r++) begin
      plan[i*100000 + t] = 3;         t += cycles_for(45, tck);
    end
    if (rfirst) begin plan[i*100000 + t] = 2; t += cycles_for(10, tck); end
    done_at[i] = t;
  endtask

  function automatic logic [3:0] pins_of(input int c);
    case (c)
      1: return 4'b0010;
      2: return 4'b0000;
      3: return 4'b0001;
      default: return 4'b0111;
    endcase
  endfunction

  task automatic check_inst(input int i, input logic [3:0] pins, input logic [10:0] addr,
                            input logic ba, input logic cke, input logic dqm, input logic done);
    int code;
    logic [3:0] e_pins;
    logic [10:0] e_addr;
    logic e_done;
    string tag;
    code = 0;
    e_done = 1'b0;
    if (!rst) begin
      if (plan.exists(i*100000 + k)) code = plan[i*100000 + k];
      e_done = (k >= done_at[i]);
    end
    e_pins = pins_of(code);
    e_addr = (code == 1) ? 11'h400 : (code == 2) ? 11'(mode_w[i]) : 11'h000;
    if (rst)                                    tag = "R1";
    else if (pins != e_pins || addr != e_addr || ba != 1'b0) begin
      if (code == 1)                            tag = "R3";
      else if (code == 2)                       tag = "R4/R6";
      else if (code == 3)                       tag = "R5/R6";
      else if (k < pause_at[i])                 tag = "R2";
      else if (k >= done_at[i])                 tag = "R8";
      else                                      tag = "R7";
    end
    else if (cke !== 1'b1)                      tag = "R10";
    else                                        tag = "R8";
    if (restarted && !rst) tag = {"R9 ", tag};
    checks++;
    if (pins !== e_pins || addr !== e_addr || ba !== 1'b0 || cke !== 1'b1 ||
        done !== e_done || dqm !== ~e_done) begin
      fails++;
      $display("FAIL %s inst%0d cycle %0d: got pins=%b addr=%h ba=%b cke=%b dqm=%b done=%b, expected pins=%b addr=%h ba=0 cke=1 dqm=%b done=%b",
               tag, i, k, pins, addr, ba, cke, dqm, done, e_pins, e_addr, ~e_done, e_done);
    end
  endtask

  always @(posedge clk) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  // Compared on every falling edge, away from the active edge (R1..R10).
  always @(negedge clk) begin
    if (!finished) begin
      check_inst(0, {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba[0], a_cke, a_dqm, a_done);
      check_inst(1, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba[0], b_cke, b_dqm, b_done);
    end
  end

  task automatic set_rst(input logic v);
    @(negedge clk);
    #2 rst = v;
  endtask

  initial begin
    build(0, 10, 400, 1'b0, 32'h232); // R6 mode first, R7 one-cycle gap after mode load
    build(1, 5, 300, 1'b1, 32'h0A5);  // R6 refresh first, R7 multi-cycle gaps
    repeat (4) @(posedge clk);        // R1 outputs held during reset
    set_rst(1'b0);
    repeat (160) @(posedge clk);      // R2 R3 R4 R5 R8 R10 full sequences
    set_rst(1'b1);
    restarted = 1'b1;
    repeat (3) @(posedge clk);
    set_rst(1'b0);
    repeat (70) @(posedge clk);       // R9 interrupted in the refresh burst
    set_rst(1'b1);
    repeat (2) @(posedge clk);
    set_rst(1'b0);
    repeat (160) @(posedge clk);      // R9 complete rerun after restart
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got no end of run, expected finish within 20000 cycles");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule